// File: doc/BRIEF.md
# Half-Strip Triad Serial Link

This block carries the hit state of one di-strip, a group of four half-strips, over a single wire. Only one of those four half-strips can hold a hit at a time. The transmit side watches the four half-strip bits. When it sees a hit, it sends a three-bit frame: a marker bit of 1, then the two-bit index of the hit half-strip. The receive side watches the wire, recognises a frame by its marker and collects the index. It then presents a one-hot four-bit vector together with a one-cycle valid strobe.

Comparator signals are slow, so a hit stays on the input for many clock cycles. For this reason the transmitter does not resend while the input stays set. It waits until the input clears, or until a programmable hold-off has expired. The number of half-strips and the width of the hold-off counter are parameters, so the link can be replicated for every di-strip of a chamber.

The receive output is a valid-only stream. A serial wire cannot be stalled, so there is no ready input. The consumer must take `dec_vec` in the cycle `dec_valid` is high. The vector then stays unchanged until the next frame completes.

Top module: `triad_link`

## Requirements
- R1: While `rst_n` is low, `ser_out`, `dec_valid` and `dec_vec` are all 0.
- R2: While the transmitter is idle and `hs_in` is all zero, `ser_out` stays 0.
- R3: The transmitter samples a non-zero `hs_in` at a clock edge while idle. From that edge on, `ser_out` carries 1 for one cycle, then address bit 1, then address bit 0, one bit per cycle. The address is the index i of the set bit `hs_in[i]`.
- R4: When more than one bit of `hs_in` is set, the address sent is the lowest set index.
- R5: Changes on `hs_in` after the marker bit do not alter the address of the frame in flight.
- R6: After the last address bit, `ser_out` is 0 for at least one cycle. With `hold_cfg` = 0, a held non-zero `hs_in` produces no further frame until `hs_in` returns to all zero.
- R7: With `hold_cfg` = H > 0 and `hs_in` held non-zero, each new marker bit appears H+3 cycles after the previous one.
- R8: The receiver ignores a 0 on `ser_in` when idle. A 1 starts a frame, and the next two bits give the address, MSB first. `dec_valid` is high for exactly one cycle, the cycle after the last address bit. At that point `dec_vec` has only bit `address` set and holds that value until the next frame completes.
- R9: The receiver decodes frames sent back to back, where a marker bit follows the previous frame's last address bit with no idle cycle in between.
- R10: With `ser_out` wired to `ser_in`, a hit sampled at edge k gives `dec_valid` high after edge k+3. `dec_vec` is then one-hot at the lowest set index of the sampled input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_in | input | HS_N | Half-strip hit levels for one di-strip |
| hold_cfg | input | HOLD_W | Resend hold-off in cycles; 0 waits for the input to clear |
| ser_out | output | 1 | Serial frame output, idle 0 |
| ser_in | input | 1 | Serial frame input to the receiver |
| dec_vec | output | HS_N | Rebuilt one-hot half-strip vector |
| dec_valid | output | 1 | One-cycle strobe marking a new `dec_vec` |

## Verification
The hardest situation to bring about is a receiver frame whose marker follows the previous address bit with no gap. The transmitter always inserts an idle cycle, so a loopback run can never produce this case. The bench therefore disconnects the loopback and drives `ser_in` bit by bit with a chain of frames packed together. The second hard case is a held input timed against the hold-off counter. Here the bench keeps `hs_in` fixed and checks the exact cycles where the line must be 0 and then must be 1 again.

// File: rtl/triad_pkg.sv
package triad_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_SEND, TX_WAIT} tx_st_e;
  typedef enum logic {RX_IDLE, RX_ADDR} rx_st_e;
endpackage

// File: rtl/triad_tx.sv
module triad_tx
  import triad_pkg::*;
#(
  parameter int HS_N   = 4,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HS_N-1:0]   hs_i,
  input  logic [HOLD_W-1:0] hold_cfg_i,
  output logic              ser_o,
  output logic              idle_o
);
  localparam int ADDR_W = (HS_N > 1) ? $clog2(HS_N) : 1;
  localparam int BC_W   = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(ADDR_W - 1);

  tx_st_e            st_q;
  logic [ADDR_W-1:0] sh_q;
  logic [BC_W-1:0]   bc_q;
  logic [HOLD_W-1:0] cnt_q;
  logic [ADDR_W-1:0] low_idx;

  // lowest set index wins: scan from the top so the last match is the lowest
  always_comb begin
    low_idx = '0;
    for (int i = HS_N - 1; i >= 0; i--) begin
      if (hs_i[i]) low_idx = ADDR_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      ser_o <= 1'b0;
      sh_q  <= '0;
      bc_q  <= '0;
      cnt_q <= '0;
    end else begin
      case (st_q)
        TX_IDLE: begin
          if (|hs_i) begin
            ser_o <= 1'b1;
            sh_q  <= low_idx;
            bc_q  <= '0;
            st_q  <= TX_SEND;
          end else begin
            ser_o <= 1'b0;
          end
        end
        TX_SEND: begin
          ser_o <= sh_q[ADDR_W-1];
          sh_q  <= sh_q << 1;
          if (bc_q == BC_LAST) begin
            st_q  <= TX_WAIT;
            cnt_q <= HOLD_W'(1);
          end else begin
            bc_q <= bc_q + 1'b1;
          end
        end
        TX_WAIT: begin
          ser_o <= 1'b0;
          if (!(|hs_i) || (cnt_q == hold_cfg_i)) begin
            st_q <= TX_IDLE;
          end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          st_q  <= TX_IDLE;
          ser_o <= 1'b0;
        end
      endcase
    end
  end

  assign idle_o = (st_q == TX_IDLE);
endmodule

// File: rtl/triad_rx.sv
module triad_rx
  import triad_pkg::*;
#(
  parameter int HS_N = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ser_i,
  output logic [HS_N-1:0] vec_o,
  output logic            valid_o
);
  localparam int ADDR_W = (HS_N > 1) ? $clog2(HS_N) : 1;
  localparam int BC_W   = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(ADDR_W - 1);

  rx_st_e            st_q;
  logic [ADDR_W-1:0] sh_q;
  logic [BC_W-1:0]   bc_q;
  logic [ADDR_W-1:0] addr_nxt;

  assign addr_nxt = ADDR_W'({sh_q, ser_i});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      sh_q    <= '0;
      bc_q    <= '0;
      vec_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (st_q)
        RX_IDLE: begin
          if (ser_i) begin
            st_q <= RX_ADDR;
            bc_q <= '0;
            sh_q <= '0;
          end
        end
        RX_ADDR: begin
          if (bc_q == BC_LAST) begin
            vec_o   <= HS_N'(1) << addr_nxt;
            valid_o <= 1'b1;
            st_q    <= RX_IDLE;
          end else begin
            sh_q <= addr_nxt;
            bc_q <= bc_q + 1'b1;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/triad_link.sv
module triad_link #(
  parameter int HS_N   = 4,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HS_N-1:0]   hs_in,
  input  logic [HOLD_W-1:0] hold_cfg,
  output logic              ser_out,
  input  logic              ser_in,
  output logic [HS_N-1:0]   dec_vec,
  output logic              dec_valid
);
  logic tx_idle;

  triad_tx #(.HS_N(HS_N), .HOLD_W(HOLD_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_i       (hs_in),
    .hold_cfg_i (hold_cfg),
    .ser_o      (ser_out),
    .idle_o     (tx_idle)
  );

  triad_rx #(.HS_N(HS_N)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_i   (ser_in),
    .vec_o   (dec_vec),
    .valid_o (dec_valid)
  );
endmodule

// File: rtl/triad_link_chk.sv
module triad_link_chk #(
  parameter int HS_N   = 4,
  parameter int HOLD_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [HS_N-1:0] hs_in,
  input logic            ser_out,
  input logic [HS_N-1:0] dec_vec,
  input logic            dec_valid,
  input logic            tx_idle
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle && hs_in == '0) |=> !ser_out); // R2
  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle && hs_in != '0) |=> ser_out); // R3
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_idle && hs_in != '0) |=> !tx_idle); // R5
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid); // R8
  AST_VEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ($countones(dec_vec) == 1)); // R8
  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> $stable(dec_vec)); // R8
endmodule

bind triad_link triad_link_chk #(.HS_N(HS_N), .HOLD_W(HOLD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hs_in     (hs_in),
  .ser_out   (ser_out),
  .dec_vec   (dec_vec),
  .dec_valid (dec_valid),
  .tx_idle   (tx_idle)
);

// File: tb/triad_link_tb.sv
module triad_link_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] hs_in = '0;
  logic [7:0] hold_cfg = '0;
  logic       ser_out;
  logic       ser_in;
  logic       ser_drv = 1'b0;
  logic       loop_en = 1'b1;
  logic [3:0] dec_vec;
  logic       dec_valid;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  assign ser_in = loop_en ? ser_out : ser_drv;

  triad_link #(.HS_N(4), .HOLD_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in), .hold_cfg(hold_cfg),
    .ser_out(ser_out), .ser_in(ser_in), .dec_vec(dec_vec), .dec_valid(dec_valid)
  );

  function automatic logic [1:0] lowest(input logic [3:0] v);
    for (int i = 0; i < 4; i++) if (v[i]) return 2'(i);
    return 2'd0;
  endfunction

  function automatic logic [3:0] onehot(input logic [1:0] a);
    return 4'b0001 << a;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // loopback frame: v applied, chg applied after the marker bit
  task automatic tx_frame(input logic [3:0] v, input logic [3:0] chg);
    logic [1:0] ea;
    ea = lowest(v);
    @(negedge clk) hs_in = v;
    @(negedge clk);
    chk(ser_out == 1'b1, "R3 marker", ser_out, 1);
    hs_in = chg;
    @(negedge clk);
    chk(ser_out == ea[1], ($countones(v) > 1) ? "R4 addr msb" : "R3 addr msb", ser_out, ea[1]);
    @(negedge clk);
    chk(ser_out == ea[0], (chg != v) ? "R5 addr lsb" : "R3 addr lsb", ser_out, ea[0]);
    @(negedge clk);
    chk(ser_out == 1'b0, "R6 gap", ser_out, 0);
    chk(dec_valid == 1'b1, "R10 valid", dec_valid, 1);
    chk(dec_vec == onehot(ea), ($countones(v) > 1) ? "R4 vec" : "R10 vec", dec_vec, onehot(ea));
    hs_in = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(ser_out == 1'b0, "R2 idle line", ser_out, 0);
      chk(dec_valid == 1'b0, "R8 pulse", dec_valid, 0);
    end
  endtask

  task automatic quiet_check(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(ser_out == 1'b0, "R2 no hit", ser_out, 0);
      chk(dec_valid == 1'b0, "R8 no frame", dec_valid, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog R1 actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int vcount;
    logic [3:0] rv, rc;
    logic [1:0] addrs [4];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(ser_out == 1'b0, "R1 ser_out", ser_out, 0);
    chk(dec_valid == 1'b0, "R1 dec_valid", dec_valid, 0);
    chk(dec_vec == 4'b0, "R1 dec_vec", dec_vec, 0);
    rst_n = 1'b1;

    quiet_check(4);

    // directed: each single index, then multi-bit and in-flight change
    for (int i = 0; i < 4; i++) tx_frame(4'b0001 << i, 4'b0001 << i);
    tx_frame(4'b1100, 4'b1100);       // R4 lowest is 2
    tx_frame(4'b1010, 4'b1010);       // R4 lowest is 1
    tx_frame(4'b1000, 4'b0001);       // R5 change to index 0 in flight
    tx_frame(4'b0100, 4'b0000);       // R5 input dropped in flight

    // R6: hold_cfg 0, held input sends once
    hold_cfg = 8'd0;
    @(negedge clk) hs_in = 4'b0010;
    vcount = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (dec_valid) vcount++;
    end
    chk(vcount == 1, "R6 single frame while held", vcount, 1);
    hs_in = '0;
    repeat (4) @(negedge clk);
    tx_frame(4'b0010, 4'b0010);       // R6 re-armed after clear

    // R7: hold-off resend spacing
    foreach (addrs[j]) addrs[j] = 2'(j);
    for (int h = 1; h <= 4; h += 3) begin
      hold_cfg = 8'(h);
      @(negedge clk) hs_in = 4'b0100;
      @(negedge clk);
      chk(ser_out == 1'b1, "R7 first marker", ser_out, 1);
      repeat (h + 2) @(negedge clk);
      chk(ser_out == 1'b0, "R7 before resend", ser_out, 0);
      @(negedge clk);
      chk(ser_out == 1'b1, "R7 resend marker", ser_out, 1);
      hs_in = '0;
      repeat (8) @(negedge clk);
    end
    hold_cfg = 8'd0;

    // R8/R9: receiver driven directly, frames packed with no gap
    loop_en = 1'b0;
    addrs[0] = 2'd2; addrs[1] = 2'd0; addrs[2] = 2'd3; addrs[3] = 2'd1;
    @(negedge clk) ser_drv = 1'b1;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      if (j > 0) chk(dec_valid == 1'b0, "R8 pulse width", dec_valid, 0);
      ser_drv = addrs[j][1];
      @(negedge clk);
      chk(dec_valid == 1'b0, "R8 no early valid", dec_valid, 0);
      ser_drv = addrs[j][0];
      @(negedge clk);
      chk(dec_valid == 1'b1, "R9 back-to-back valid", dec_valid, 1);
      chk(dec_vec == onehot(addrs[j]), "R9 back-to-back vec", dec_vec, onehot(addrs[j]));
      ser_drv = (j < 3) ? 1'b1 : 1'b0;
    end
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(dec_valid == 1'b0, "R8 idle zeros ignored", dec_valid, 0);
      chk(dec_vec == onehot(2'd1), "R8 vec held", dec_vec, onehot(2'd1));
    end
    loop_en = 1'b1;
    repeat (2) @(negedge clk);

    // constrained random loopback frames
    for (int n = 0; n < 40; n++) begin
      hold_cfg = 8'($urandom_range(0, 3));
      rv = 4'($urandom_range(0, 15));
      rc = ($urandom_range(0, 1) == 1) ? 4'($urandom_range(0, 15)) : rv;
      if (rv == 4'b0) quiet_check(3);
      else tx_frame(rv, rc);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule